// File: doc/BRIEF.md
# Serial Controller Register Readback Decoder

This block sits between the bus interface of a two-channel serial communications controller and its register file. It holds the write-side registers, decodes the enhancement option bits from them, and places the right value on the read data bus for each read access. A read normally returns the native read-register value at the requested index. When extended readback is active, a small set of normally write-only registers is instead aliased onto fixed read indices, so software can read back what it programmed.

Two option bits in write register 15 and one bit in the auxiliary register 7-prime form the enable chain. Bit 0 of WR15 opens the auxiliary register: while it is set, writes to index 7 land in WR7-prime rather than WR7. Bit 2 of WR15 reports the status FIFO enhancement and works on its own. Bit 6 of WR7-prime turns on extended readback, but only while WR15 bit 0 is set. The read data is selected combinationally from the index and captured on the read strobe. The serial datapath, the FIFO storage and interrupt logic live elsewhere.

Top module: `scc_rdback_dec`

## Requirements
- R1: After reset, all write registers, WR7-prime, `rd_data_o` and the three flags are zero.
- R2: `aux_en_o` equals bit 0 of WR15 and changes only through a write to index 15.
- R3: `fifo_en_o` equals bit 2 of WR15, whatever bit 0 of WR15 or WR7-prime hold, and changes only through a write to index 15.
- R4: `ext_rd_o` is high exactly when WR15 bit 0 and WR7-prime bit 6 are both set.
- R5: While `ext_rd_o` is high, read index 9 returns WR3, 4 returns WR4, 5 returns WR5, 11 returns WR10 and 14 returns WR7-prime.
- R6: While `ext_rd_o` is low, every read index returns its native read-register byte from `rr_native_i` (byte i at bits 8i+7..8i).
- R7: While `ext_rd_o` is high, every read index other than 4, 5, 9, 11 and 14 returns its native byte.
- R8: A write to index 7 updates WR7-prime when WR15 bit 0 is set and WR7 otherwise; the other of the two keeps its value.
- R9: `rd_data_o` takes the selected value on the clock edge where `rd_stb_i` is high and holds it on every other edge.
- R10: With WR15 bit 2 set and bit 0 clear, extended readback stays off even when WR7-prime bit 6 is set, and all indices return native bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | AW | Write register index |
| wr_data_i | input | DW | Write data |
| rd_stb_i | input | 1 | Read strobe, captures read data |
| rd_idx_i | input | AW | Read register index |
| rr_native_i | input | DW*2^AW | Native read-register values, byte i at index i |
| rd_data_o | output | DW | Registered read data |
| aux_en_o | output | 1 | Auxiliary register access enabled |
| fifo_en_o | output | 1 | Status FIFO enhancement enabled |
| ext_rd_o | output | 1 | Extended readback active |

## Verification
The bench walks every read index under all five enable combinations plus the all-clear state, so a wrong alias table, an alias leaking onto a neighbouring index, or aliasing left on when it should be off shows as a wrong byte at a specific index. The FIFO-only case is driven with WR7-prime bit 6 already set; a design that ignored the WR15 bit 0 gate would return write registers there. Writes to index 7 are made with the auxiliary enable both clear and set, and a redirect that went the wrong way would turn extended readback on or off at the wrong moment and change the byte read at index 14. A hold check moves the index and the native values without a strobe, catching a read register that follows its input freely.

// File: rtl/scc_rdback_pkg.sv
package scc_rdback_pkg;

  localparam int WR7_IDX  = 7;
  localparam int WR15_IDX = 15;
  localparam int AUX_BIT  = 0;
  localparam int FIFO_BIT = 2;
  localparam int EXT_BIT  = 6;
  localparam int NALIAS   = 5;

  typedef struct packed {
    logic aux_en;
    logic fifo_en;
    logic ext_rd;
  } opt_t;

  // read index that shows an aliased write register
  function automatic int alias_rr(input int k);
    case (k)
      0:       return 9;
      1:       return 4;
      2:       return 5;
      3:       return 14;
      default: return 11;
    endcase
  endfunction

  // source write register; WR7_IDX stands for the auxiliary WR7-prime
  function automatic int alias_src(input int k);
    case (k)
      0:       return 3;
      1:       return 4;
      2:       return 5;
      3:       return WR7_IDX;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/scc_wreg_file.sv
module scc_wreg_file
  import scc_rdback_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] wregs_o [1<<AW],
  output logic [DW-1:0] wr7p_o
);
  localparam int NREG = 1 << AW;

  logic aux_en;
  assign aux_en = wregs_o[WR15_IDX][AUX_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    if (i == WR7_IDX) begin : g_redir
      assign hit = wr_en_i && (wr_idx_i == AW'(i)) && !aux_en;
    end else begin : g_plain
      assign hit = wr_en_i && (wr_idx_i == AW'(i));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  wregs_o[i] <= '0;
      else if (hit) wregs_o[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      wr7p_o <= '0;
    else if (wr_en_i && (wr_idx_i == AW'(WR7_IDX)) && aux_en)
      wr7p_o <= wr_data_i;
  end

endmodule

// File: rtl/scc_opt_decode.sv
module scc_opt_decode
  import scc_rdback_pkg::*;
(
  input  logic aux_bit_i,
  input  logic fifo_bit_i,
  input  logic ext_bit_i,
  output opt_t opt_o
);
  always_comb begin
    opt_o.aux_en  = aux_bit_i;
    opt_o.fifo_en = fifo_bit_i;
    // extended readback lives behind the auxiliary register gate
    opt_o.ext_rd  = aux_bit_i && ext_bit_i;
  end
endmodule

// File: rtl/scc_rd_mux.sv
module scc_rd_mux
  import scc_rdback_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          ext_rd_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wregs_i  [1<<AW],
  input  logic [DW-1:0] wr7p_i,
  input  logic [DW-1:0] native_i [1<<AW],
  output logic [DW-1:0] data_o
);
  logic [NALIAS-1:0] hit;
  logic [DW-1:0]     src [NALIAS];

  for (genvar k = 0; k < NALIAS; k++) begin : g_alias
    localparam int RR  = alias_rr(k);
    localparam int SRC = alias_src(k);
    assign hit[k] = ext_rd_i && (idx_i == AW'(RR));
    if (SRC == WR7_IDX) begin : g_aux
      assign src[k] = wr7p_i;
    end else begin : g_wr
      assign src[k] = wregs_i[SRC];
    end
  end

  always_comb begin
    data_o = native_i[idx_i];
    for (int k = 0; k < NALIAS; k++)
      if (hit[k]) data_o = src[k];
  end
endmodule

// File: rtl/scc_rdback_dec.sv
module scc_rdback_dec
  import scc_rdback_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_idx_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      rd_stb_i,
  input  logic [AW-1:0]             rd_idx_i,
  input  logic [DW*(1<<AW)-1:0]     rr_native_i,
  output logic [DW-1:0]             rd_data_o,
  output logic                      aux_en_o,
  output logic                      fifo_en_o,
  output logic                      ext_rd_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] wregs  [NREG];
  logic [DW-1:0] native [NREG];
  logic [DW-1:0] wr7p;
  logic [DW-1:0] rd_next;
  opt_t          opt;

  for (genvar i = 0; i < NREG; i++) begin : g_nat
    assign native[i] = rr_native_i[i*DW +: DW];
  end

  scc_wreg_file #(.DW(DW), .AW(AW)) u_wregs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .wregs_o   (wregs),
    .wr7p_o    (wr7p)
  );

  scc_opt_decode u_opt (
    .aux_bit_i  (wregs[WR15_IDX][AUX_BIT]),
    .fifo_bit_i (wregs[WR15_IDX][FIFO_BIT]),
    .ext_bit_i  (wr7p[EXT_BIT]),
    .opt_o      (opt)
  );

  scc_rd_mux #(.DW(DW), .AW(AW)) u_mux (
    .ext_rd_i (opt.ext_rd),
    .idx_i    (rd_idx_i),
    .wregs_i  (wregs),
    .wr7p_i   (wr7p),
    .native_i (native),
    .data_o   (rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= rd_next;
  end

  assign aux_en_o  = opt.aux_en;
  assign fifo_en_o = opt.fifo_en;
  assign ext_rd_o  = opt.ext_rd;

endmodule

// File: rtl/scc_rdback_chk.sv
module scc_rdback_chk
  import scc_rdback_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [AW-1:0]         wr_idx_i,
  input logic                  rd_stb_i,
  input logic [AW-1:0]         rd_idx_i,
  input logic [DW*(1<<AW)-1:0] rr_native_i,
  input logic [DW-1:0]         rd_data_o,
  input logic                  aux_en_o,
  input logic                  fifo_en_o,
  input logic                  ext_rd_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] nat [NREG];
  for (genvar i = 0; i < NREG; i++) begin : g_nat
    assign nat[i] = rr_native_i[i*DW +: DW];
  end

  logic wr15;
  assign wr15 = wr_en_i && (wr_idx_i == AW'(WR15_IDX));

  p_aux_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr15 |=> $stable(aux_en_o));

  p_fifo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr15 |=> $stable(fifo_en_o));

  p_ext_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_o |-> aux_en_o);

  p_aux_reg_self_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i && ext_rd_o && (rd_idx_i == AW'(14)) |=> rd_data_o[EXT_BIT]);

  p_native_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i && !ext_rd_o |=> rd_data_o == $past(nat[rd_idx_i]));

  p_read_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o));

endmodule

bind scc_rdback_dec scc_rdback_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .rd_stb_i    (rd_stb_i),
  .rd_idx_i    (rd_idx_i),
  .rr_native_i (rr_native_i),
  .rd_data_o   (rd_data_o),
  .aux_en_o    (aux_en_o),
  .fifo_en_o   (fifo_en_o),
  .ext_rd_o    (ext_rd_o)
);

// File: tb/scc_rdback_dec_test.sv
`timescale 1ns/1ps
module scc_rdback_dec_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NREG = 1 << AW;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                wr_en_i = 1'b0;
  logic [AW-1:0]       wr_idx_i = '0;
  logic [DW-1:0]       wr_data_i = '0;
  logic                rd_stb_i = 1'b0;
  logic [AW-1:0]       rd_idx_i = '0;
  logic [DW*NREG-1:0]  rr_native_i = '0;
  logic [DW-1:0]       rd_data_o;
  logic                aux_en_o, fifo_en_o, ext_rd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] wm [NREG];
  logic [7:0] w7p;
  logic [7:0] nat [NREG];

  always #10 clk_i = ~clk_i;

  scc_rdback_dec #(.DW(DW), .AW(AW)) uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_native(input logic [7:0] seed);
    for (int i = 0; i < NREG; i++) begin
      nat[i] = seed ^ 8'(i * 8'h13);
      rr_native_i[i*DW +: DW] = nat[i];
    end
  endtask

  task automatic wreg(input int idx, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = AW'(idx); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (idx == 7 && wm[15][0]) w7p = d;
    else wm[idx] = d;
  endtask

  function automatic bit m_ext();
    return wm[15][0] & w7p[6];
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    if (m_ext()) begin
      case (i)
        9:  return wm[3];
        4:  return wm[4];
        5:  return wm[5];
        14: return w7p;
        11: return wm[10];
        default: return nat[i];
      endcase
    end
    return nat[i];
  endfunction

  task automatic chk_flags();
    chk("R2 aux_en", {7'd0, aux_en_o}, {7'd0, wm[15][0]});
    chk("R3 fifo_en", {7'd0, fifo_en_o}, {7'd0, wm[15][2]});
    chk("R4 ext_rd", {7'd0, ext_rd_o}, {7'd0, m_ext()});
  endtask

  task automatic rd(input int i, input string tag);
    @(negedge clk_i);
    rd_stb_i = 1'b1; rd_idx_i = AW'(i);
    @(negedge clk_i);
    rd_stb_i = 1'b0;
    chk(tag, rd_data_o, exp_rd(i));
  endtask

  task automatic sweep(input string off_tag);
    for (int i = 0; i < NREG; i++) begin
      if (!m_ext()) rd(i, off_tag);
      else if (i == 4 || i == 5 || i == 9 || i == 11 || i == 14) rd(i, "R5 alias");
      else rd(i, "R7 native with ext");
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) wm[i] = '0;
    w7p = '0;
    load_native(8'h5A);
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rd_data", rd_data_o, 8'h00);
    chk("R1 flags", {5'd0, aux_en_o, fifo_en_o, ext_rd_o}, 8'h00);
    sweep("R6 native all clear");

    wreg(3, 8'h33); wreg(4, 8'h44); wreg(5, 8'h55); wreg(10, 8'hA1);
    wreg(7, 8'h40);             // R8: lands in WR7, aux closed
    wreg(15, 8'h01); chk_flags();
    chk("R8 WR7 write kept out of aux", {7'd0, ext_rd_o}, 8'h00);
    sweep("R6 aux only");

    wreg(7, 8'h4C); chk_flags(); // R8: lands in WR7-prime
    sweep("R6");
    rd(14, "R8 aux register readback");

    wreg(15, 8'h04); chk_flags();
    chk("R10 ext off fifo only", {7'd0, ext_rd_o}, 8'h00);
    sweep("R10 fifo only native");

    wreg(15, 8'h05); chk_flags();
    load_native(8'hC3);
    sweep("R6");

    wreg(7, 8'h0E); chk_flags();
    sweep("R6 fifo and aux no ext");

    wreg(15, 8'h04);
    wreg(7, 8'h77);             // R8: aux closed, goes to WR7
    wreg(15, 8'h05); chk_flags();
    rd(14, "R8 aux untouched");
    wreg(7, 8'h60); chk_flags();
    rd(14, "R8 aux written");
    wreg(3, 8'h9D);
    rd(9, "R5 updated WR3");

    // R9 hold without strobe
    rd(14, "R9 capture");
    @(negedge clk_i);
    rd_idx_i = AW'(2);
    load_native(8'h11);
    repeat (3) @(negedge clk_i);
    chk("R9 hold", rd_data_o, 8'h60);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule